// File: doc/BRIEF.md
# UART Transmit-Empty Holdoff Timer

This block decides when a 16550-style UART may raise its "transmit holding register empty" status after software pushes a byte into the transmit queue. It does not use one fixed delay. Each push loads a down-counter with roughly one character duration, counted in 16x oversampling ticks. The duration is decoded from the line format bits: word length, parity enable and extra stop bit. The counter decrements once per 16x baud tick. The empty-set enable stays low while the counter is nonzero and goes high again when the counter reaches zero. The UART's status logic uses that enable to decide when the empty flag may be set again.

The format code `line_fmt` is four bits:
- Bits [1:0] give the word length: 00 = 5 bits, 01 = 6 bits, 10 = 7 bits, 11 = 8 bits.
- Bit [2] requests an extra stop period: a full bit, or half a bit for 5-bit words.
- Bit [3] adds a parity bit.

The loaded value covers the start bit, the data bits, the parity bit when enabled, and the extra stop period when requested. It does not include the first stop bit. Each full bit is worth 16 ticks and each half bit is worth 8 ticks. The value loaded is that total minus one.

Top module: `thre_holdoff_timer`

## Requirements
- R1: While reset is asserted and after it is released, the counter holds zero and `thre_set_en` is 1.
- R2: With `line_fmt[3:2]`=00, a push loads 16*(6+`line_fmt[1:0]`)-1: 95, 111, 127 or 143 for 5 to 8 data bits.
- R3: Setting `line_fmt[3]` (parity) adds 16 to the loaded value for every word length and stop setting.
- R4: Setting `line_fmt[2]` (extra stop) adds 8 when `line_fmt[1:0]`=00 and adds 16 otherwise; the largest value is 175.
- R5: The counter decrements by one only on clock edges where `baud16_tick` is 1; on other edges it holds its value.
- R6: `thre_set_en` is 0 from the edge after a push until the counter reaches zero, and is 1 exactly when the counter is zero. After a push it returns to 1 after exactly the loaded value of ticked edges.
- R7: A push that arrives while the counter is nonzero reloads it from the `line_fmt` value present at that push.
- R8: At zero, with no push, the counter stays at zero on ticked edges and `thre_set_en` stays 1.
- R9: A push on an edge where `baud16_tick` is also 1 loads the full value, with no decrement on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| baud16_tick | input | 1 | One-cycle 16x baud enable |
| txq_push | input | 1 | Write strobe into the transmit queue |
| line_fmt | input | 4 | Format code: [1:0] word length, [2] extra stop, [3] parity |
| thre_set_en | output | 1 | High when the empty status may be set |

## Verification
Every fault inside the block shows up in the length of the low window on `thre_set_en`, measured in ticked edges after a push. A wrong decode, a missing or extra decrement, or a lost reload makes that window end early, end late, or never end. A push that fails to load shows one cycle after the push, as the enable staying high. A bad count length shows only when the window ends, up to 175 ticks later. The bench therefore measures the window length for every format code under several tick spacings, including pushes that coincide with a tick and pushes that interrupt a running count.

// File: rtl/thre_holdoff_pkg.sv
package thre_holdoff_pkg;

  typedef struct packed {
    logic       parity;
    logic       extra_stop;
    logic [1:0] wlen;
  } line_fmt_t;

  // Length of the timed part of a frame in half-bit units: start bit,
  // data bits and optional parity, plus the optional extra stop period.
  function automatic int unsigned frame_half_bits(line_fmt_t f);
    int unsigned hb;
    hb = 2 * (6 + int'(f.wlen) + int'(f.parity));
    if (f.extra_stop)
      hb = hb + ((f.wlen == 2'b00) ? 1 : 2);
    return hb;
  endfunction

endpackage

// File: rtl/thre_rst_sync.sv
module thre_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/thre_fmt_decode.sv
module thre_fmt_decode
  import thre_holdoff_pkg::*;
#(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned CNT_W      = 8
) (
  input  logic [3:0]       fmt,
  output logic [CNT_W-1:0] load_val
);
  localparam int unsigned HALF_TICKS = OVERSAMPLE / 2;
  localparam int unsigned MAX_HALF   = 22;
  localparam int unsigned MAX_VAL    = MAX_HALF * HALF_TICKS - 1;

  line_fmt_t   f;
  int unsigned ticks;

  always_comb begin
    f        = line_fmt_t'(fmt);
    ticks    = frame_half_bits(f) * HALF_TICKS - 1;
    load_val = CNT_W'(ticks);
  end

  initial begin
    a_r4_width_fits: assert (MAX_VAL < (1 << CNT_W))
      else $error("counter too narrow for longest frame");
  end
endmodule

// File: rtl/thre_down_counter.sv
module thre_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] count,
  output logic             is_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (step && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count   = cnt_q;
  assign is_zero = ~|cnt_q;

  a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cnt_q));
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/thre_holdoff_timer.sv
module thre_holdoff_timer #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned CNT_W      = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud16_tick,
  input  logic       txq_push,
  input  logic [3:0] line_fmt,
  output logic       thre_set_en
);
  logic             srst_n;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             is_zero;

  thre_rst_sync u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  thre_fmt_decode #(
    .OVERSAMPLE (OVERSAMPLE),
    .CNT_W      (CNT_W)
  ) u_decode (
    .fmt      (line_fmt),
    .load_val (load_val)
  );

  thre_down_counter #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (txq_push),
    .load_val (load_val),
    .step     (baud16_tick),
    .count    (count),
    .is_zero  (is_zero)
  );

  assign thre_set_en = is_zero;

  a_r6_low_after_push: assert property (@(posedge clk) disable iff (!srst_n)
    txq_push |=> !thre_set_en);
  a_r2_load_in_range: assert property (@(posedge clk) disable iff (!srst_n)
    txq_push |-> (load_val >= CNT_W'(6*OVERSAMPLE - 1) &&
                  load_val <= CNT_W'(11*OVERSAMPLE - 1)));
  a_r6_rise_only_from_one: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(thre_set_en) |-> ($past(count) == CNT_W'(1) && $past(baud16_tick)));
endmodule

// File: tb/thre_holdoff_timer_bench.sv
module thre_holdoff_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud16_tick;
  logic       txq_push;
  logic [3:0] line_fmt;
  logic       thre_set_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  thre_holdoff_timer u_thre_holdoff_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud16_tick (baud16_tick),
    .txq_push    (txq_push),
    .line_fmt    (line_fmt),
    .thre_set_en (thre_set_en)
  );

  function automatic int expect_ticks(logic [3:0] f);
    int v;
    v = 16 * (6 + int'(f[1:0]) + int'(f[3])) - 1;
    if (f[2]) v = v + ((f[1:0] == 2'b00) ? 8 : 16);
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Push with a tick on the same edge, then count ticked edges until the
  // enable returns, spacing ticks every 'per' cycles; stop at 'limit'.
  task automatic push_and_count(input logic [3:0] f, input int per,
                                input int limit, output int n, output int low_after);
    int ph;
    @(negedge clk);
    txq_push = 1'b1; line_fmt = f; baud16_tick = 1'b1;
    @(negedge clk);
    txq_push = 1'b0; baud16_tick = 1'b0;
    low_after = thre_set_en ? 0 : 1;
    n = 0; ph = 0;
    while (!thre_set_en && n < limit) begin
      baud16_tick = (ph == per - 1);
      ph = (ph == per - 1) ? 0 : ph + 1;
      @(posedge clk);
      if (baud16_tick) n++;
      @(negedge clk);
    end
    baud16_tick = 1'b0;
  endtask

  initial begin
    int n, lo;
    rst_n = 1'b0; baud16_tick = 1'b0; txq_push = 1'b0; line_fmt = 4'h0;
    repeat (3) @(negedge clk);
    check("R1 enable during reset", int'(thre_set_en), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 enable after reset", int'(thre_set_en), 1);

    // R8: ticks at zero, no push
    baud16_tick = 1'b1;
    repeat (5) @(negedge clk);
    baud16_tick = 1'b0;
    check("R8 stays at zero", int'(thre_set_en), 1);

    // Full sweep of format codes under several tick spacings (R2/R3/R4/R5/R6/R9)
    for (int per = 1; per <= 3; per++) begin
      for (int f = 0; f < 16; f++) begin
        string req;
        push_and_count(4'(f), per, 400, n, lo);
        check("R6 low after push", lo, 1);
        if (per > 1)            req = "R5 tick spacing";
        else if (f[3])          req = "R3 parity";
        else if (f[2])          req = "R4 extra stop";
        else                    req = "R2 word length";
        check({req, " / R9 window"}, n, expect_ticks(4'(f)));
        // R8: idle ticks keep the enable high
        @(negedge clk); baud16_tick = 1'b1;
        @(negedge clk); baud16_tick = 1'b0;
        check("R8 idle after count", int'(thre_set_en), 1);
      end
    end

    // R7: interrupted count reloads from the new format
    push_and_count(4'h0, 1, 40, n, lo);
    check("R7 partial still low", int'(thre_set_en), 0);
    push_and_count(4'hF, 1, 400, n, lo);
    check("R7 reload long format", n, 175);
    push_and_count(4'hF, 2, 30, n, lo);
    push_and_count(4'h4, 1, 400, n, lo);
    check("R7 reload short format", n, 103);

    // R5: no ticks, enable must stay low
    push_and_count(4'h1, 1, 0, n, lo);
    repeat (300) @(negedge clk);
    check("R5 hold without ticks", int'(thre_set_en), 0);
    push_and_count(4'h1, 1, 400, n, lo);
    check("R5 resume after hold", n, 111);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule